// File: doc/BRIEF.md
# Asynchronous Parallel-Flash Write Cycle Sequencer

This block lives on the host side of a parallel NOR-style flash bus and turns a single request into one complete asynchronous write cycle. A request is a 23-bit word address, a 16-bit data word and an address-presentation mode. It is accepted through a ready/valid handshake. The sequencer then walks the active-low strobes through an optional address-latch phase, a setup phase, a write-enable pulse and a hold phase. Address and data stay stable on the bus throughout, and a one-cycle completion pulse marks the end of the cycle.

There are two ways to present the address. In held mode the address-valid strobe stays low for the whole cycle, so the memory captures address and data together on the rising edge of write enable. In pulsed mode address-valid drops for a programmed number of cycles at the start of the cycle. It returns high before write enable falls. The length of every phase comes from a cycle-count parameter on the sequencer's own clock. No bus clock is involved in the write.

Top module: `nor_write_seq`

## Requirements
- R1: While reset is asserted and afterwards until the first request, chip enable, write enable and address-valid are high (inactive), the data-bus drive enable is low, busy is low and req_ready is high.
- R2: The output-enable strobe and the memory reset strobe are held high (inactive) in every cycle.
- R3: A request is accepted only in a cycle where req_valid and req_ready are both high. req_ready stays low while busy is high, so every accepted request produces exactly one write cycle, and cycles occur in acceptance order.
- R4: In held mode (adv_pulse_mode = 0 at acceptance), address-valid is low in every cycle in which chip enable is low.
- R5: In pulsed mode (adv_pulse_mode = 1 at acceptance), address-valid is low for exactly ADV_CYC cycles at the start of the chip-enable window. It is high again before write enable falls and stays high for the rest of the cycle.
- R6: Write enable falls only while chip enable is low. The number of cycles with chip enable low before write enable falls is SETUP_CYC in held mode and ADV_CYC + SETUP_CYC in pulsed mode.
- R7: Write enable stays low for exactly PULSE_CYC consecutive cycles per write.
- R8: Bus address and data equal the accepted request and do not change while chip enable is low. Chip enable stays low for exactly HOLD_CYC cycles after write enable rises.
- R9: The data-bus drive enable is high exactly in the cycles where write enable is low or the hold phase is running, and low otherwise.
- R10: done is a single-cycle pulse in the last hold cycle. busy is high for exactly SETUP_CYC + PULSE_CYC + HOLD_CYC cycles (plus ADV_CYC in pulsed mode) from the cycle after acceptance, and falls right after done.
- R11: The mode is captured at acceptance. Changing adv_pulse_mode while a cycle is in flight has no effect on that cycle's address-valid waveform.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock; all phase counts are in cycles of this clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_addr | input | 23 | Word address of the request |
| req_data | input | 16 | Data word of the request |
| adv_pulse_mode | input | 1 | 0 = hold address-valid low for the whole cycle, 1 = pulse it first |
| busy | output | 1 | A write cycle is in progress |
| done | output | 1 | One-cycle pulse in the last hold cycle |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_oe_n | output | 1 | Output enable, active low, always inactive |
| bus_rst_n | output | 1 | Memory reset, active low, always inactive |
| bus_adv_n | output | 1 | Address valid, active low |
| bus_addr | output | 23 | Address bus |
| bus_dq_out | output | 16 | Data bus value to drive |
| bus_dq_oe | output | 1 | Data bus drive enable |

## Verification
The assertions check the per-cycle relations on every cycle: output-enable and memory reset are always inactive, write enable is low only under chip enable, address-valid matches the captured mode, the data drive enable covers the write pulse, address and data stay put under chip enable, and busy follows acceptance and done. Only the bench scenarios can show the phase lengths and their sums. The same holds for the correspondence between each bus cycle and the request that caused it, ordering under back-pressure, and the fact that a mode change during a cycle is ignored.

// File: rtl/nwr_pkg.sv
package nwr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADV   = 3'd1,
    PH_SETUP = 3'd2,
    PH_PULSE = 3'd3,
    PH_HOLD  = 3'd4
  } nwr_phase_e;
endpackage

// File: rtl/nwr_req_latch.sv
module nwr_req_latch #(
  parameter int AW = 23,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  input  logic          mode_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q,
  output logic          mode_q
);
  // Captured only on acceptance; stable for the whole bus cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      mode_q <= 1'b0;
    end else if (load) begin
      addr_q <= addr_in;
      data_q <= data_in;
      mode_q <= mode_in;
    end
  end
endmodule

// File: rtl/nwr_phase_ctr.sv
module nwr_phase_ctr #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clear | run;
    cnt_d  = clear ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/nwr_seq_fsm.sv
module nwr_seq_fsm
  import nwr_pkg::*;
#(
  parameter int ADV_CYC   = 2,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       mode_in,
  output nwr_phase_e phase,
  output logic       done
);
  localparam int MAX_AS = (ADV_CYC > SETUP_CYC) ? ADV_CYC : SETUP_CYC;
  localparam int MAX_PH = (PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC;
  localparam int MAXC   = (MAX_AS > MAX_PH) ? MAX_AS : MAX_PH;
  localparam int CW     = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] ADV_M1   = CW'(ADV_CYC - 1);
  localparam logic [CW-1:0] SETUP_M1 = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] PULSE_M1 = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] HOLD_M1  = CW'(HOLD_CYC - 1);

  nwr_phase_e    phase_d;
  logic [CW-1:0] cnt;
  logic [CW-1:0] len_m1;
  logic          last;
  logic          advance;
  logic          active;

  always_comb begin
    unique case (phase)
      PH_ADV:   len_m1 = ADV_M1;
      PH_SETUP: len_m1 = SETUP_M1;
      PH_PULSE: len_m1 = PULSE_M1;
      PH_HOLD:  len_m1 = HOLD_M1;
      default:  len_m1 = '0;
    endcase
    active  = (phase != PH_IDLE);
    last    = active && (cnt == len_m1);
    advance = last || accept;
    done    = (phase == PH_HOLD) && last;
  end

  always_comb begin
    phase_d = phase;
    unique case (phase)
      PH_IDLE:  if (accept) phase_d = mode_in ? PH_ADV : PH_SETUP;
      PH_ADV:   if (last)   phase_d = PH_SETUP;
      PH_SETUP: if (last)   phase_d = PH_PULSE;
      PH_PULSE: if (last)   phase_d = PH_HOLD;
      PH_HOLD:  if (last)   phase_d = PH_IDLE;
      default:              phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_d;
  end

  nwr_phase_ctr #(.CW(CW)) ctr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (advance),
    .run   (active),
    .cnt   (cnt)
  );

  // The counter never passes the current phase's limit.
  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= len_m1));
endmodule

// File: rtl/nwr_strobe_dec.sv
module nwr_strobe_dec
  import nwr_pkg::*;
(
  input  nwr_phase_e phase,
  input  logic       mode_q,
  output logic       ce_n,
  output logic       we_n,
  output logic       adv_n,
  output logic       dq_oe
);
  always_comb begin
    ce_n  = 1'b1;
    we_n  = 1'b1;
    adv_n = 1'b1;
    dq_oe = 1'b0;
    unique case (phase)
      PH_ADV: begin
        ce_n  = 1'b0;
        adv_n = 1'b0;
      end
      PH_SETUP: begin
        ce_n  = 1'b0;
        adv_n = mode_q;
      end
      PH_PULSE: begin
        ce_n  = 1'b0;
        we_n  = 1'b0;
        adv_n = mode_q;
        dq_oe = 1'b1;
      end
      PH_HOLD: begin
        ce_n  = 1'b0;
        adv_n = mode_q;
        dq_oe = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/nor_write_seq.sv
module nor_write_seq
  import nwr_pkg::*;
#(
  parameter int AW        = 23,
  parameter int DW        = 16,
  parameter int ADV_CYC   = 2,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          adv_pulse_mode,
  output logic          busy,
  output logic          done,
  output logic          bus_ce_n,
  output logic          bus_we_n,
  output logic          bus_oe_n,
  output logic          bus_rst_n,
  output logic          bus_adv_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dq_out,
  output logic          bus_dq_oe
);
  nwr_phase_e phase;
  logic       accept;
  logic       mode_q;

  always_comb begin
    req_ready = (phase == PH_IDLE);
    busy      = (phase != PH_IDLE);
    accept    = req_valid && req_ready;
    bus_oe_n  = 1'b1;
    bus_rst_n = 1'b1;
  end

  nwr_req_latch #(.AW(AW), .DW(DW)) latch_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .addr_in (req_addr),
    .data_in (req_data),
    .mode_in (adv_pulse_mode),
    .addr_q  (bus_addr),
    .data_q  (bus_dq_out),
    .mode_q  (mode_q)
  );

  nwr_seq_fsm #(
    .ADV_CYC   (ADV_CYC),
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) fsm_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .mode_in (adv_pulse_mode),
    .phase   (phase),
    .done    (done)
  );

  nwr_strobe_dec dec_i (
    .phase  (phase),
    .mode_q (mode_q),
    .ce_n   (bus_ce_n),
    .we_n   (bus_we_n),
    .adv_n  (bus_adv_n),
    .dq_oe  (bus_dq_oe)
  );

  assert_idle_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_n && bus_rst_n);
  assert_accept_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_ready));
  assert_held_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ce_n && !mode_q) |-> !bus_adv_n);
  assert_adv_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_n |-> (bus_adv_n == mode_q));
  assert_we_under_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_n |-> !bus_ce_n);
  assert_bus_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ce_n && $past(!bus_ce_n)) |-> ($stable(bus_addr) && $stable(bus_dq_out)));
  assert_dq_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_n |-> bus_dq_oe);
  assert_dq_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ce_n |-> !bus_dq_oe);
  assert_done_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));
endmodule

// File: tb/nor_write_seq_tb_top.sv
module nor_write_seq_tb_top;
  localparam int A_C = 2;
  localparam int S_C = 2;
  localparam int P_C = 3;
  localparam int H_C = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [22:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic        adv_pulse_mode = 1'b0;
  logic        busy, done;
  logic        bus_ce_n, bus_we_n, bus_oe_n, bus_rst_n, bus_adv_n, bus_dq_oe;
  logic [22:0] bus_addr;
  logic [15:0] bus_dq_out;

  always #4 clk = ~clk;

  nor_write_seq #(
    .ADV_CYC(A_C), .SETUP_CYC(S_C), .PULSE_CYC(P_C), .HOLD_CYC(H_C)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .adv_pulse_mode(adv_pulse_mode),
    .busy(busy), .done(done), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
    .bus_oe_n(bus_oe_n), .bus_rst_n(bus_rst_n), .bus_adv_n(bus_adv_n),
    .bus_addr(bus_addr), .bus_dq_out(bus_dq_out), .bus_dq_oe(bus_dq_oe)
  );

  typedef struct packed {
    logic [22:0] a;
    logic [15:0] d;
    logic        m;
  } item_t;

  item_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;
  int n_sent = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send(input logic [22:0] a, input logic [15:0] d, input logic m);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d; adv_pulse_mode = m;
    while (!req_ready) @(negedge clk);
    exp_q.push_back('{a: a, d: d, m: m});
    n_sent++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor / scoreboard state
  logic        prev_ce_n = 1'b1, prev_we_n = 1'b1, prev_busy = 1'b0;
  int          pre_cnt, adv_cnt, we_cnt, hold_cnt, busy_cnt;
  logic        last_mode = 1'b0;
  logic [22:0] cap_addr;
  logic [15:0] cap_data;
  int r2_err = 0, stab_err = 0, oe_err = 0, adv_err = 0, idle_err = 0, rdy_err = 0;
  int done_seen = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic cur_m;
      logic exp_oe;
      cur_m = (exp_q.size() > 0) ? exp_q[0].m : last_mode;
      if (!(bus_oe_n && bus_rst_n)) r2_err++;
      if (busy && req_ready) rdy_err++;
      if (!bus_ce_n) begin
        if (prev_ce_n) begin
          pre_cnt = 0; adv_cnt = 0; we_cnt = 0; hold_cnt = 0;
          cap_addr = bus_addr; cap_data = bus_dq_out;
        end else if (bus_addr !== cap_addr || bus_dq_out !== cap_data) stab_err++;
        if (!bus_we_n) begin
          if (prev_we_n) begin
            chk(pre_cnt == (cur_m ? A_C + S_C : S_C), "R6 setup cycles", pre_cnt, cur_m ? A_C + S_C : S_C);
            chk(adv_cnt == (cur_m ? A_C : S_C), cur_m ? "R5 adv pulse cycles" : "R4 adv held cycles", adv_cnt, cur_m ? A_C : S_C);
          end
          we_cnt++;
          if (bus_adv_n !== cur_m) adv_err++;
        end else if (we_cnt == 0) begin
          pre_cnt++;
          if (!bus_adv_n) begin
            adv_cnt++;
            if (cur_m && pre_cnt > A_C) adv_err++;
          end
        end else begin
          if (!prev_we_n) begin
            chk(we_cnt == P_C, "R7 we pulse width", we_cnt, P_C);
            if (exp_q.size() > 0) begin
              item_t it;
              it = exp_q.pop_front();
              chk(bus_addr == it.a, "R8 address", bus_addr, it.a);
              chk(bus_dq_out == it.d, "R8 data", bus_dq_out, it.d);
              last_mode = it.m;
            end else chk(0, "R3 unexpected write", 1, 0);
          end
          hold_cnt++;
          if (bus_adv_n !== last_mode) adv_err++;
        end
        exp_oe = !bus_we_n || (we_cnt > 0 && bus_we_n);
        if (bus_dq_oe !== exp_oe) oe_err++;
      end else begin
        if (!prev_ce_n) chk(hold_cnt == H_C, "R8 hold cycles", hold_cnt, H_C);
        if (!bus_we_n || !bus_adv_n || bus_dq_oe) idle_err++;
      end
      if (done) begin
        done_seen++;
        chk(!bus_ce_n && bus_we_n && we_cnt > 0 && hold_cnt == H_C, "R10 done in last hold", hold_cnt, H_C);
      end
      if (busy) busy_cnt++;
      if (!busy && prev_busy) begin
        chk(busy_cnt == S_C + P_C + H_C + (last_mode ? A_C : 0), "R10 busy length",
            busy_cnt, S_C + P_C + H_C + (last_mode ? A_C : 0));
        busy_cnt = 0;
      end
      prev_ce_n = bus_ce_n; prev_we_n = bus_we_n; prev_busy = busy;
    end else busy_cnt = 0;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_ce_n && bus_we_n && bus_adv_n && !bus_dq_oe, "R1 strobes in reset",
        {bus_ce_n, bus_we_n, bus_adv_n, bus_dq_oe}, 4'b1110);
    chk(!busy && req_ready, "R1 busy/ready in reset", {busy, req_ready}, 2'b01);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(bus_ce_n && bus_we_n && bus_adv_n && !bus_dq_oe && !busy && req_ready,
        "R1 idle after reset", {bus_ce_n, bus_we_n, bus_adv_n, bus_dq_oe, busy, req_ready}, 6'b111001);

    send(23'h012345, 16'hA5C3, 1'b0);   // held mode
    send(23'h7FFFFF, 16'hFFFF, 1'b1);   // pulsed, all ones, back-to-back (R3)
    send(23'h000000, 16'h0000, 1'b0);   // held, all zeros, back-to-back
    // R11: flip mode input while the held cycle is in flight
    send(23'h2AAAAA, 16'h5555, 1'b0);
    adv_pulse_mode = 1'b1;
    repeat (4) @(negedge clk);
    adv_pulse_mode = 1'b0;
    send(23'h555555, 16'hAAAA, 1'b1);
    send(23'h001F00, 16'h8001, 1'b1);

    while (exp_q.size() > 0 || busy) @(negedge clk);
    repeat (4) @(negedge clk);

    chk(done_seen == n_sent, "R3 one cycle per request", done_seen, n_sent);
    chk(r2_err == 0, "R2 oe/reset strobes high", r2_err, 0);
    chk(rdy_err == 0, "R3 ready low while busy", rdy_err, 0);
    chk(adv_err == 0, "R4 R5 R11 adv waveform", adv_err, 0);
    chk(stab_err == 0, "R8 bus stable under ce", stab_err, 0);
    chk(oe_err == 0, "R9 data drive enable", oe_err, 0);
    chk(idle_err == 0, "R1 idle strobes", idle_err, 0);
    chk(bus_ce_n && !busy && req_ready, "R1 idle at end", {bus_ce_n, busy, req_ready}, 3'b101);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule